// File: doc/BRIEF.md
# UART Transmitter with Timeguard

This block serialises one byte at a time onto an asynchronous serial line. A frame is a low start bit, the data bits with the least significant first, an optional parity bit of selectable sense, and one or two high stop bits. After the stop bits the block can hold the line high for a programmable number of extra bit periods, the timeguard, before the next frame may begin.

Software or a bus adapter writes a byte into a single holding register when the ready flag is high. The serialiser takes that byte on a baud tick, and ready rises at the moment its start bit appears. The timeguard counts as part of the frame in flight. A byte waiting behind it therefore keeps ready low for the whole gap, and the empty flag stays low until the gap ends. Bit timing comes from a one-cycle baud tick supplied from outside, and every line bit lasts exactly one tick period.

Top module: `uart_tg_tx`

## Requirements
- R1: After synchronous reset the line is high, `tx_ready` is 1 and `tx_empty` is 1.
- R2: A frame starts with a low start bit, followed by 8 data bits with bit 0 first.
- R3: When `par_en` is 1, a parity bit follows the data. With `par_odd`=0 the parity bit is the XOR of the data bits (even). With `par_odd`=1 it is the inverse (odd). When `par_en` is 0 no parity bit is sent.
- R4: After the data (or parity) the line is high for one stop bit when `two_stop`=0 and for two when `two_stop`=1.
- R5: Every bit, including each timeguard bit, lasts exactly one baud-tick period. The line changes only in the cycle after a tick.
- R6: A byte written while the block is empty starts its start bit on the next baud tick, within one tick period of the write.
- R7: With `tg_len`=0 and a byte already waiting, the next start bit directly follows the last stop bit.
- R8: With `tg_len`=N>0, the line stays high for N extra bit periods after the stop bits. Consecutive start bits are therefore (10 + parity + extra stop + N) tick periods apart.
- R9: `tx_ready` rises only in the cycle in which a start bit begins. While a byte waits behind a timeguard, `tx_ready` stays low through the whole gap.
- R10: `tx_empty` is low during the stop bits and the timeguard. It rises only after the gap ends with no byte waiting, and only while the line is high.
- R11: A write while `tx_ready` is 0 is ignored. The waiting byte is kept, and no extra frame is sent.
- R12: The largest `tg_len` of 255 produces a gap of exactly 255 bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| par_en | input | 1 | Enable parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| tg_len | input | 8 | Timeguard length in bit periods, 0 disables it |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding register free |
| tx_empty | output | 1 | Nothing held and no frame or gap in progress |

## Verification
The bench first sends bursts of bytes with and without a gap. It measures the distance between consecutive start bits: a design that dropped the gap, added a bit, or delayed a back-to-back frame by an idle tick would show a different interval. During each gap bit it checks that ready stays low while a byte waits and that empty stays low. A design that freed the holding register early, or treated the gap as idle time, would fail these checks. It also drives the maximum gap of 255, which would expose a counter that wraps or is one short. Finally it writes into a full holding register; a design that overwrote the waiting byte or sent an extra frame would be caught by the scoreboard.

// File: rtl/uart_tg_pkg.sv
// Shared definitions for the timeguard UART transmitter.
// Assumes: one frame state machine; the encoding is internal to the block.
package uart_tg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_GAP
    } tx_state_e;
endpackage

// File: rtl/uart_tg_hold.sv
// Single-entry holding register in front of the serialiser.
// Assumes: take is only raised while full; writes into a full entry are dropped.
module uart_tg_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Capture a byte when empty, release it when the serialiser takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/uart_tg_cnt.sv
// Loadable down-counter shared by data, stop and timeguard phases.
// Assumes: load wins over dec; zero flags a count of zero.
module uart_tg_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] count;

    // Hold, reload or step the phase count.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (load)    count <= load_val;
        else if (dec)     count <= count - 1'b1;
    end

    assign zero = (count == '0);
endmodule

// File: rtl/uart_tg_seq.sv
// Frame sequencer: start, data LSB first, optional parity, stop bits, timeguard.
// Assumes: all transitions happen on baud_tick; configuration is read live and
// should only change while the transmitter is empty.
module uart_tg_seq
    import uart_tg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic [TG_W-1:0]   tg_len,
    output logic              take,
    output logic              txd,
    output logic              busy
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int CNT_W = (TG_W > IDX_W) ? TG_W : IDX_W;

    tx_state_e         state, nxt;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              load_char;
    logic              cnt_ld, cnt_dec, cnt_zero;
    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  stop_val;

    assign stop_val = two_stop ? CNT_W'(1) : '0;

    uart_tg_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_ld),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // Next-state, counter control and byte take decisions per tick.
    always_comb begin
        nxt       = state;
        take      = 1'b0;
        load_char = 1'b0;
        cnt_ld    = 1'b0;
        cnt_dec   = 1'b0;
        cnt_val   = '0;
        if (baud_tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (hold_full) begin
                        take      = 1'b1;
                        load_char = 1'b1;
                        nxt       = ST_START;
                    end
                end
                ST_START: begin
                    nxt     = ST_DATA;
                    cnt_ld  = 1'b1;
                    cnt_val = CNT_W'(DATA_W - 1);
                end
                ST_DATA: begin
                    if (!cnt_zero) begin
                        cnt_dec = 1'b1;
                    end else if (par_en) begin
                        nxt = ST_PAR;
                    end else begin
                        nxt     = ST_STOP;
                        cnt_ld  = 1'b1;
                        cnt_val = stop_val;
                    end
                end
                ST_PAR: begin
                    nxt     = ST_STOP;
                    cnt_ld  = 1'b1;
                    cnt_val = stop_val;
                end
                ST_STOP, ST_GAP: begin
                    if (!cnt_zero) begin
                        cnt_dec = 1'b1;
                    end else if (state == ST_STOP && tg_len != '0) begin
                        nxt     = ST_GAP;
                        cnt_ld  = 1'b1;
                        cnt_val = CNT_W'(tg_len - TG_W'(1));
                    end else if (hold_full) begin
                        take      = 1'b1;
                        load_char = 1'b1;
                        nxt       = ST_START;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State, shift register and parity bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else begin
            state <= nxt;
            if (load_char) begin
                shreg   <= hold_data;
                par_bit <= (^hold_data) ^ par_odd;
            end else if (baud_tick && state == ST_DATA) begin
                shreg <= shreg >> 1;
            end
        end
    end

    // Line level for the current phase.
    always_comb begin
        unique case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/uart_tg_tx.sv
// Top of the timeguard UART transmitter: holding register plus frame sequencer.
// Assumes: baud_tick is a single-cycle pulse from an external rate generator.
module uart_tg_tx #(
    parameter int DATA_W = 8,
    parameter int TG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic [TG_W-1:0]   tg_len,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;

    uart_tg_hold #(.DATA_W(DATA_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tg_seq #(.DATA_W(DATA_W), .TG_W(TG_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .two_stop  (two_stop),
        .tg_len    (tg_len),
        .take      (take),
        .txd       (txd),
        .busy      (busy)
    );

    assign tx_ready = !hold_full;
    assign tx_empty = !hold_full && !busy;
endmodule

// File: rtl/uart_tg_tx_chk.sv
// Port-level protocol checks for uart_tg_tx, attached by bind.
// Assumes: synchronous active-low reset held for at least one clock at start.
module uart_tg_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic txd,
    input logic tx_ready,
    input logic tx_empty
);
    // R1: the first cycle out of reset shows an idle, free transmitter.
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (txd && tx_ready && tx_empty));

    // R5: the line only moves in the cycle after a baud tick.
    a_r5_bit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(baud_tick)) |-> $stable(txd));

    // R9: ready only rises together with a start bit.
    a_r9_ready_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> !txd);

    // R10: empty implies a free holding register and an idle-high line.
    a_r10_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (tx_ready && txd));

    // R10: empty never rises while the line is low.
    a_r10_empty_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> txd);
endmodule

bind uart_tg_tx uart_tg_tx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .txd       (txd),
    .tx_ready  (tx_ready),
    .tx_empty  (tx_empty)
);

// File: tb/test_uart_tg_tx.sv
`timescale 1ns/1ps
module test_uart_tg_tx;
    localparam int N = 8;  // clocks per baud tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic [7:0] tg_len = '0;
    logic       txd, tx_ready, tx_empty;

    uart_tg_tx i_uart_tg_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .tg_len(tg_len), .txd(txd),
        .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [7:0] d;
        bit         pe, po, two, b2b, last;
        int         tg;
        longint     wcyc;
    } item_t;

    item_t  q[$];
    int     n_chk = 0, n_fail = 0;
    longint cyc = 0;
    bit     done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // baud tick generator: one pulse every N clocks
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            baud_tick = (c == N - 1);
            c = (c + 1) % N;
        end
    end

    // driver: wait for ready, queue expectation, write the byte
    task automatic send(input logic [7:0] d, input bit b2b, input bit last);
        item_t it;
        do @(negedge clk); while (!tx_ready);
        it.d = d; it.pe = par_en; it.po = par_odd; it.two = two_stop;
        it.tg = int'(tg_len); it.b2b = b2b; it.last = last; it.wcyc = cyc;
        q.push_back(it);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!tx_empty);
        repeat (3 * N) @(negedge clk);
    endtask

    task automatic config_line(input bit pe, input bit po, input bit two, input int tg);
        par_en = pe; par_odd = po; two_stop = two; tg_len = 8'(tg);
    endtask

    // monitor: detect start bits, pop expectations, compare every bit
    initial begin
        longint prev_start = 0;
        int     prev_len = 0;
        logic   prev_txd;
        @(posedge rst_n);
        @(negedge clk);
        prev_txd = txd;
        forever begin
            item_t  it;
            longint s;
            int     ns, len;
            @(negedge clk);
            if (!(prev_txd && !txd)) begin
                prev_txd = txd;
                continue;
            end
            s = cyc;
            if (q.size() == 0) begin
                chk(0, "R11 unexpected frame", 1, 0);
                prev_txd = txd;
                continue;
            end
            it = q.pop_front();
            ns = it.two ? 2 : 1;
            len = 1 + 8 + (it.pe ? 1 : 0) + ns + it.tg;
            if (it.b2b) begin
                if (it.tg == 0) chk(s - prev_start == prev_len * N, "R7 back-to-back interval", s - prev_start, prev_len * N);
                else if (it.tg == 255) chk(s - prev_start == prev_len * N, "R12 max gap interval", s - prev_start, prev_len * N);
                else chk(s - prev_start == prev_len * N, "R5 R8 gap interval", s - prev_start, prev_len * N);
            end else begin
                chk(s - it.wcyc >= 1 && s - it.wcyc <= N + 1, "R6 start latency", s - it.wcyc, N);
            end
            chk(tx_ready == 1'b1, "R9 ready at start", tx_ready, 1);
            repeat (N / 2) @(negedge clk);
            chk(txd == 1'b0, "R2 start bit", txd, 0);
            for (int i = 0; i < 8; i++) begin
                repeat (N) @(negedge clk);
                chk(txd == it.d[i], "R2 data bit", txd, it.d[i]);
            end
            if (it.pe) begin
                repeat (N) @(negedge clk);
                chk(txd == ((^it.d) ^ it.po), "R3 parity bit", txd, (^it.d) ^ it.po);
            end
            for (int i = 0; i < ns; i++) begin
                repeat (N) @(negedge clk);
                chk(txd == 1'b1, "R4 stop bit", txd, 1);
                chk(tx_empty == 1'b0, "R10 empty low in stop", tx_empty, 0);
            end
            for (int g = 0; g < it.tg; g++) begin
                repeat (N) @(negedge clk);
                chk(txd == 1'b1, "R8 gap line high", txd, 1);
                chk(tx_empty == 1'b0, "R10 empty low in gap", tx_empty, 0);
                if (q.size() > 0 && q[0].b2b)
                    chk(tx_ready == 1'b0, "R9 ready low in gap", tx_ready, 0);
            end
            prev_start = s;
            prev_len = len;
            if (it.last) begin
                repeat (N) @(negedge clk);
                chk(txd == 1'b1, "R10 line idle after frame", txd, 1);
                chk(tx_empty == 1'b1, "R10 empty after gap", tx_empty, 1);
                chk(tx_ready == 1'b1, "R10 ready after gap", tx_ready, 1);
            end
            prev_txd = txd;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    // stimulus
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset line high", txd, 1);
        chk(tx_ready == 1'b1, "R1 reset ready", tx_ready, 1);
        chk(tx_empty == 1'b1, "R1 reset empty", tx_empty, 1);
        repeat (2 * N) @(negedge clk);

        // single byte, no parity, one stop, no gap
        config_line(0, 0, 0, 0);
        send(8'hA5, 0, 1);
        wait_idle();

        // burst with even parity, no gap: back to back
        config_line(1, 0, 0, 0);
        send(8'h3C, 0, 0);
        send(8'h81, 1, 0);
        send(8'h7E, 1, 1);
        wait_idle();

        // odd parity, two stops, gap of 4
        config_line(1, 1, 1, 4);
        send(8'h01, 0, 0);
        send(8'hFE, 1, 0);
        send(8'h55, 1, 1);
        wait_idle();

        // minimal gap, and a write into a full holding register
        config_line(0, 0, 1, 1);
        send(8'h96, 0, 0);
        send(8'h4B, 1, 1);
        @(negedge clk);
        chk(tx_ready == 1'b0, "R11 ready low before extra write", tx_ready, 0);
        wr_en = 1'b1; wr_data = 8'hC3;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        repeat (30 * N) @(negedge clk);
        chk(q.size() == 0, "R11 no extra frame", q.size(), 0);
        chk(txd == 1'b1 && tx_empty == 1'b1, "R11 line idle after ignored write", {txd, tx_empty}, 3);

        // maximum gap
        config_line(0, 0, 0, 255);
        send(8'hF0, 0, 0);
        send(8'h0F, 1, 1);
        wait_idle();

        done = 1;
        finish_run();
    end
endmodule